// File: doc/BRIEF.md
# Submission/Completion Ring Descriptor Engine

This block runs one DMA channel's pair of work rings. Software places 32-byte work entries in a submission ring in memory. It then advances the submission tail register, which acts as the doorbell. Whenever the engine's own submission head trails that tail, the engine reads the next entry one 32-bit word at a time over a request/acknowledge read port. It pulls the operation code, the interrupt request flag, the two attribute fields, the byte count and the two 64-bit addresses out of those words.

For a supported operation the engine passes the count and both addresses to a copy datapath with a single start pulse, then waits for that datapath's done pulse. Next it writes a 16-byte completion record into the completion ring through a request/acknowledge write port. The record carries the updated submission head and a status word. The status word packs a phase-style valid flag with a 15-bit status code.

Both rings have a depth that is programmed as depth minus one, and both indices wrap at that value. Software consumes completion records and hands the slots back by writing the completion head register. The engine never fills the last free completion slot, so it stalls instead.

Top module: `ring_desc_engine`

## Requirements
- R1: After `rst`, or in the cycle after a one-cycle `ptr_clr`, the submission head, submission tail, completion head and completion tail are all zero, the completion valid phase is 1, and no read or write request is raised.
- R2: While the submission head equals the submission tail, no read request is raised. Once they differ, the engine issues exactly eight word reads at `sq_base + head*32 + 4*k` for k = 0..7, in order.
- R3: Opcode field word0[3:0] equal to 4 or 1 yields one single-cycle `cp_start`. While it is high, `cp_len` = word3, `cp_src` = {word5, word4}, `cp_dst` = {word7, word6}, `cp_src_attr` = word0[14:12] and `cp_dst_attr` = word2[26:24].
- R4: Any other opcode produces no `cp_start`. Its completion record carries status code 1. Supported operations carry status code 0.
- R5: A completion is written as four word writes at `cq_base + tail*16 + 4*k`. Words 0 and 1 are zero. Word 2 bits [15:0] hold the submission head after the entry was consumed, with the upper bits zero. Word 3 bits [31:17] hold the status code, bit [16] holds the valid flag, and bits [15:0] are zero.
- R6: The submission head advances by one after each entry's eighth word is read, and it goes from `sq_depth_m1` back to 0.
- R7: The completion tail advances by one after the fourth completion word is acknowledged, and it goes from `cq_depth_m1` back to 0. The valid flag written into records starts at 1 and inverts each time the tail wraps to 0.
- R8: If advancing the completion tail would make it equal the software completion head, no completion write is issued. The engine waits until software writes a head value that frees a slot.
- R9: `cpl_irq` pulses for one cycle when a completion finishes, if the entry's word0 bit 8 was set. It stays low otherwise.
- R10: `rd_req` and `wr_req` are never high together. A raised request holds its address steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_clr | input | 1 | Clears all ring indices and aborts work in one cycle |
| sq_base | input | ADDR_W | Submission ring base byte address |
| cq_base | input | ADDR_W | Completion ring base byte address |
| sq_depth_m1 | input | PTR_W | Submission ring depth minus one |
| cq_depth_m1 | input | PTR_W | Completion ring depth minus one |
| sq_tail_we | input | 1 | Doorbell strobe for the submission tail |
| sq_tail_wdata | input | PTR_W | New submission tail |
| cq_head_we | input | 1 | Strobe for the software completion head |
| cq_head_wdata | input | PTR_W | New completion head |
| rd_req | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Word read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Word write request |
| wr_addr | output | ADDR_W | Word write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| cp_start | output | 1 | Copy start pulse |
| cp_len | output | 32 | Copy byte count |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_src_attr | output | 3 | Source attribute |
| cp_dst_attr | output | 3 | Destination attribute |
| cp_done | input | 1 | Copy finished pulse |
| cpl_irq | output | 1 | Completion interrupt pulse |
| sq_head_o | output | PTR_W | Current submission head |
| cq_tail_o | output | PTR_W | Current completion tail |

## Verification
The bench builds the engine with its default widths: 10-bit indices and 64-bit addresses. It then programs small ring depths at run time, eight submission slots and four completion slots. With those depths, a few dozen entries carry both indices through several wraps and invert the valid flag repeatedly. A completion ring of four slots fills after three records, so the stall and its release can be reached with directed steps. Random opcodes, lengths and addresses are mixed in to cover both the copy path and the rejected-opcode path.

// File: rtl/rde_pkg.sv
package rde_pkg;

    localparam int WORD_W     = 32;
    localparam int XADDR_W    = 64;
    localparam int SQE_WORDS  = 8;
    localparam int CQE_WORDS  = 4;

    localparam logic [3:0]  OPC_MEM2MEM = 4'h4;
    localparam logic [3:0]  OPC_SMALL   = 4'h1;
    localparam logic [14:0] STS_OK      = 15'd0;
    localparam logic [14:0] STS_BAD_OPC = 15'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_COPY,
        ST_CQ_WAIT,
        ST_CQ_WR
    } eng_state_e;

    typedef struct packed {
        logic [3:0]         opcode;
        logic               irq_en;
        logic [2:0]         src_attr;
        logic [2:0]         dst_attr;
        logic [WORD_W-1:0]  len;
        logic [XADDR_W-1:0] src;
        logic [XADDR_W-1:0] dst;
    } work_item_t;

    // Fold one fetched word into the partially assembled work item.
    function automatic work_item_t absorb_word(input work_item_t cur,
                                               input logic [2:0] idx,
                                               input logic [WORD_W-1:0] w);
        work_item_t s = cur;
        case (idx)
            3'd0: begin
                s.opcode   = w[3:0];
                s.irq_en   = w[8];
                s.src_attr = w[14:12];
            end
            3'd2: s.dst_attr   = w[26:24];
            3'd3: s.len        = w;
            3'd4: s.src[31:0]  = w;
            3'd5: s.src[63:32] = w;
            3'd6: s.dst[31:0]  = w;
            3'd7: s.dst[63:32] = w;
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic op_supported(input logic [3:0] op);
        return (op == OPC_MEM2MEM) || (op == OPC_SMALL);
    endfunction

    // Word k of the 16-byte completion record.
    function automatic logic [WORD_W-1:0] cpl_word(input logic [1:0]  k,
                                                   input logic [15:0] head,
                                                   input logic [14:0] status,
                                                   input logic        valid);
        case (k)
            2'd2:    return {16'h0000, head};
            2'd3:    return {status, valid, 16'h0000};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rde_ring_ptrs.sv
module rde_ring_ptrs #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PTR_W-1:0] sq_depth_m1,
    input  logic [PTR_W-1:0] cq_depth_m1,
    input  logic             sq_tail_we,
    input  logic [PTR_W-1:0] sq_tail_wdata,
    input  logic             cq_head_we,
    input  logic [PTR_W-1:0] cq_head_wdata,
    input  logic             sq_adv,
    input  logic             cq_adv,
    output logic [PTR_W-1:0] sq_head,
    output logic [PTR_W-1:0] cq_tail,
    output logic             phase,
    output logic             sq_pending,
    output logic             cq_full
);

    logic [PTR_W-1:0] sq_tail, cq_head;
    logic [PTR_W-1:0] sq_head_nx, cq_tail_nx;

    assign sq_head_nx = (sq_head == sq_depth_m1) ? '0 : sq_head + 1'b1;
    assign cq_tail_nx = (cq_tail == cq_depth_m1) ? '0 : cq_tail + 1'b1;

    assign sq_pending = (sq_head != sq_tail);
    assign cq_full    = (cq_tail_nx == cq_head);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sq_head <= '0;
            sq_tail <= '0;
            cq_head <= '0;
            cq_tail <= '0;
            phase   <= 1'b1;
        end else begin
            if (sq_tail_we) sq_tail <= sq_tail_wdata;
            if (cq_head_we) cq_head <= cq_head_wdata;
            if (sq_adv)     sq_head <= sq_head_nx;
            if (cq_adv) begin
                cq_tail <= cq_tail_nx;
                if (cq_tail == cq_depth_m1) phase <= ~phase;
            end
        end
    end

endmodule

// File: rtl/rde_engine_ctrl.sv
module rde_engine_ctrl
    import rde_pkg::*;
#(
    parameter int PTR_W  = 10,
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                sq_pending,
    input  logic                cq_full,
    input  logic [PTR_W-1:0]    sq_head,
    input  logic [PTR_W-1:0]    cq_tail,
    input  logic                phase,
    input  logic [ADDR_W-1:0]   sq_base,
    input  logic [ADDR_W-1:0]   cq_base,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_ack,
    input  logic [WORD_W-1:0]   rd_data,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WORD_W-1:0]   wr_data,
    input  logic                wr_ack,
    output logic                cp_start,
    output work_item_t          item,
    input  logic                cp_done,
    output logic                sq_adv,
    output logic                cq_adv,
    output logic                cpl_irq
);

    localparam int SQE_SHIFT = $clog2(SQE_WORDS * 4);
    localparam int CQE_SHIFT = $clog2(CQE_WORDS * 4);

    eng_state_e  state;
    logic [2:0]  wcnt;
    logic [14:0] status;

    assign rd_req  = (state == ST_FETCH);
    assign rd_addr = sq_base + ADDR_W'({sq_head, SQE_SHIFT'(0)})
                             + ADDR_W'({wcnt, 2'b00});
    assign wr_req  = (state == ST_CQ_WR);
    assign wr_addr = cq_base + ADDR_W'({cq_tail, CQE_SHIFT'(0)})
                             + ADDR_W'({wcnt[1:0], 2'b00});
    assign wr_data = cpl_word(wcnt[1:0], 16'(sq_head), status, phase);

    assign sq_adv = (state == ST_FETCH) && rd_ack && (wcnt == 3'(SQE_WORDS - 1));
    assign cq_adv = (state == ST_CQ_WR) && wr_ack && (wcnt == 3'(CQE_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            status   <= STS_OK;
            item     <= '0;
            cp_start <= 1'b0;
            cpl_irq  <= 1'b0;
        end else begin
            cp_start <= 1'b0;
            cpl_irq  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    wcnt <= '0;
                    if (sq_pending) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        item <= absorb_word(item, wcnt, rd_data);
                        wcnt <= wcnt + 1'b1;
                        if (sq_adv) state <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (op_supported(item.opcode)) begin
                        status   <= STS_OK;
                        cp_start <= 1'b1;
                        state    <= ST_COPY;
                    end else begin
                        status <= STS_BAD_OPC;
                        state  <= ST_CQ_WAIT;
                    end
                end
                ST_COPY: begin
                    if (cp_done) state <= ST_CQ_WAIT;
                end
                ST_CQ_WAIT: begin
                    wcnt <= '0;
                    if (!cq_full) state <= ST_CQ_WR;
                end
                ST_CQ_WR: begin
                    if (wr_ack) begin
                        wcnt <= wcnt + 1'b1;
                        if (cq_adv) begin
                            cpl_irq <= item.irq_en;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ring_desc_engine.sv
module ring_desc_engine
    import rde_pkg::*;
#(
    parameter int PTR_W  = 10,
    parameter int ADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ptr_clr,
    input  logic [ADDR_W-1:0]  sq_base,
    input  logic [ADDR_W-1:0]  cq_base,
    input  logic [PTR_W-1:0]   sq_depth_m1,
    input  logic [PTR_W-1:0]   cq_depth_m1,
    input  logic               sq_tail_we,
    input  logic [PTR_W-1:0]   sq_tail_wdata,
    input  logic               cq_head_we,
    input  logic [PTR_W-1:0]   cq_head_wdata,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_ack,
    input  logic [31:0]        rd_data,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [31:0]        wr_data,
    input  logic               wr_ack,
    output logic               cp_start,
    output logic [31:0]        cp_len,
    output logic [63:0]        cp_src,
    output logic [63:0]        cp_dst,
    output logic [2:0]         cp_src_attr,
    output logic [2:0]         cp_dst_attr,
    input  logic               cp_done,
    output logic               cpl_irq,
    output logic [PTR_W-1:0]   sq_head_o,
    output logic [PTR_W-1:0]   cq_tail_o
);

    logic       sq_pending, cq_full, phase, sq_adv, cq_adv;
    work_item_t item;

    rde_ring_ptrs #(.PTR_W(PTR_W)) ptrs_i (
        .clk           (clk),
        .rst           (rst),
        .clr           (ptr_clr),
        .sq_depth_m1   (sq_depth_m1),
        .cq_depth_m1   (cq_depth_m1),
        .sq_tail_we    (sq_tail_we),
        .sq_tail_wdata (sq_tail_wdata),
        .cq_head_we    (cq_head_we),
        .cq_head_wdata (cq_head_wdata),
        .sq_adv        (sq_adv),
        .cq_adv        (cq_adv),
        .sq_head       (sq_head_o),
        .cq_tail       (cq_tail_o),
        .phase         (phase),
        .sq_pending    (sq_pending),
        .cq_full       (cq_full)
    );

    rde_engine_ctrl #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (ptr_clr),
        .sq_pending (sq_pending),
        .cq_full    (cq_full),
        .sq_head    (sq_head_o),
        .cq_tail    (cq_tail_o),
        .phase      (phase),
        .sq_base    (sq_base),
        .cq_base    (cq_base),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ack     (wr_ack),
        .cp_start   (cp_start),
        .item       (item),
        .cp_done    (cp_done),
        .sq_adv     (sq_adv),
        .cq_adv     (cq_adv),
        .cpl_irq    (cpl_irq)
    );

    assign cp_len      = item.len;
    assign cp_src      = item.src;
    assign cp_dst      = item.dst;
    assign cp_src_attr = item.src_attr;
    assign cp_dst_attr = item.dst_attr;

endmodule

// File: rtl/rde_checker.sv
module rde_checker #(
    parameter int PTR_W  = 10,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ptr_clr,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_ack,
    input logic              cp_start,
    input logic              cpl_irq,
    input logic [PTR_W-1:0]  sq_head_o,
    input logic [PTR_W-1:0]  cq_tail_o
);

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !ptr_clr) |=> (rd_req && $stable(rd_addr)));

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && !ptr_clr) |=> (wr_req && $stable(wr_addr)));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cp_start |=> !cp_start);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_irq |=> !cpl_irq);

    // R1
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (sq_head_o == '0 && cq_tail_o == '0 && !rd_req && !wr_req));

    // R6
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ptr_clr |=> (sq_head_o == $past(sq_head_o)
                   || sq_head_o == PTR_W'($past(sq_head_o) + 1'b1)
                   || sq_head_o == '0));

    // R7
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ptr_clr |=> (cq_tail_o == $past(cq_tail_o)
                   || cq_tail_o == PTR_W'($past(cq_tail_o) + 1'b1)
                   || cq_tail_o == '0));

endmodule

bind ring_desc_engine rde_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ptr_clr   (ptr_clr),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_ack    (wr_ack),
    .cp_start  (cp_start),
    .cpl_irq   (cpl_irq),
    .sq_head_o (sq_head_o),
    .cq_tail_o (cq_tail_o)
);

// File: tb/ring_desc_engine_tb_top.sv
module ring_desc_engine_tb_top;

    localparam int PW = 10;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ptr_clr = 1'b0;
    logic [AW-1:0] sq_base = 64'h0000_0012_3400_0000;
    logic [AW-1:0] cq_base = 64'h0000_0056_7800_0000;
    logic [PW-1:0] sq_depth_m1 = 10'd7;
    logic [PW-1:0] cq_depth_m1 = 10'd3;
    logic          sq_tail_we = 1'b0;
    logic [PW-1:0] sq_tail_wdata = '0;
    logic          cq_head_we = 1'b0;
    logic [PW-1:0] cq_head_wdata = '0;
    logic          rd_req, wr_req, cp_start, cpl_irq;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          rd_ack = 1'b0, wr_ack = 1'b0, cp_done = 1'b0;
    logic [31:0]   rd_data = '0, wr_data, cp_len;
    logic [63:0]   cp_src, cp_dst;
    logic [2:0]    cp_src_attr, cp_dst_attr;
    logic [PW-1:0] sq_head_o, cq_tail_o;

    always #5 clk = ~clk;

    ring_desc_engine #(.PTR_W(PW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ptr_clr(ptr_clr),
        .sq_base(sq_base), .cq_base(cq_base),
        .sq_depth_m1(sq_depth_m1), .cq_depth_m1(cq_depth_m1),
        .sq_tail_we(sq_tail_we), .sq_tail_wdata(sq_tail_wdata),
        .cq_head_we(cq_head_we), .cq_head_wdata(cq_head_wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .cp_start(cp_start), .cp_len(cp_len), .cp_src(cp_src), .cp_dst(cp_dst),
        .cp_src_attr(cp_src_attr), .cp_dst_attr(cp_dst_attr),
        .cp_done(cp_done), .cpl_irq(cpl_irq),
        .sq_head_o(sq_head_o), .cq_tail_o(cq_tail_o)
    );

    // ---------------- memory, copy and interrupt models ----------------
    logic [31:0] sq_mem [logic [63:0]];
    logic [31:0] cq_mem [logic [63:0]];
    logic [63:0] rd_log [0:511];
    int          rd_cnt = 0, cp_cnt = 0, irq_cnt = 0, cp_dly = 0;
    logic [31:0] cap_len;
    logic [63:0] cap_src, cap_dst;
    logic [2:0]  cap_sattr, cap_dattr;

    function automatic logic [31:0] sq_peek(input logic [63:0] a);
        return sq_mem.exists(a) ? sq_mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] cq_peek(input logic [63:0] a);
        return cq_mem.exists(a) ? cq_mem[a] : 32'hDEAD_BEEF;
    endfunction

    always @(posedge clk) begin
        if (rst) rd_ack <= 1'b0;
        else if (rd_req && !rd_ack) begin
            rd_ack  <= 1'b1;
            rd_data <= sq_peek(rd_addr);
            rd_log[rd_cnt % 512] <= rd_addr;
            rd_cnt  <= rd_cnt + 1;
        end else rd_ack <= 1'b0;
    end

    always @(posedge clk) begin
        if (rst) wr_ack <= 1'b0;
        else if (wr_req && !wr_ack) begin
            wr_ack <= 1'b1;
            cq_mem[wr_addr] = wr_data;
        end else wr_ack <= 1'b0;
    end

    always @(posedge clk) begin
        cp_done <= 1'b0;
        if (rst) cp_dly <= 0;
        else if (cp_start) begin
            cap_len <= cp_len; cap_src <= cp_src; cap_dst <= cp_dst;
            cap_sattr <= cp_src_attr; cap_dattr <= cp_dst_attr;
            cp_cnt <= cp_cnt + 1;
            cp_dly <= 3;
        end else if (cp_dly != 0) begin
            cp_dly <= cp_dly - 1;
            if (cp_dly == 1) cp_done <= 1'b1;
        end
    end

    always @(posedge clk) if (!rst && cpl_irq) irq_cnt <= irq_cnt + 1;

    // ---------------- scoreboard ----------------
    int checks = 0, errors = 0;
    int e_head = 0, e_tail = 0, e_phase = 1;
    int rb, cb, ib, cur_idx;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wrapn(input int p, input int m1);
        return (p == m1) ? 0 : p + 1;
    endfunction

    task automatic put_entry(input logic [3:0] op, input logic irq,
                             input logic [2:0] sa, input logic [2:0] da,
                             input logic [31:0] len, input logic [63:0] src,
                             input logic [63:0] dst);
        logic [63:0] a;
        a = sq_base + 64'(e_head) * 64'd32;
        sq_mem[a]      = {17'h0, sa, 3'h0, irq, 4'h0, op};
        sq_mem[a + 4]  = 32'h1111_1111;
        sq_mem[a + 8]  = {5'h0, da, 24'h0};
        sq_mem[a + 12] = len;
        sq_mem[a + 16] = src[31:0];
        sq_mem[a + 20] = src[63:32];
        sq_mem[a + 24] = dst[31:0];
        sq_mem[a + 28] = dst[63:32];
        rb = rd_cnt; cb = cp_cnt; ib = irq_cnt; cur_idx = e_head;
        @(negedge clk);
        sq_tail_we = 1'b1; sq_tail_wdata = PW'(wrapn(e_head, int'(sq_depth_m1)));
        @(negedge clk);
        sq_tail_we = 1'b0;
    endtask

    task automatic set_cq_head(input int h);
        @(negedge clk);
        cq_head_we = 1'b1; cq_head_wdata = PW'(h);
        @(negedge clk);
        cq_head_we = 1'b0;
    endtask

    task automatic finish_entry(input logic [3:0] op, input logic irq,
                                input logic [2:0] sa, input logic [2:0] da,
                                input logic [31:0] len, input logic [63:0] src,
                                input logic [63:0] dst);
        logic        sup;
        logic [14:0] st;
        logic [63:0] ca, sa_base;
        int          prev;
        prev = e_tail;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (int'(cq_tail_o) != prev) break;
        end
        repeat (2) @(negedge clk);
        sup = (op == 4'h4) || (op == 4'h1);
        st  = sup ? 15'd0 : 15'd1;
        e_head = wrapn(e_head, int'(sq_depth_m1));
        ca = cq_base + 64'(e_tail) * 64'd16;
        sa_base = sq_base + 64'(cur_idx) * 64'd32;
        // R2: eight ordered reads from the entry slot
        chk("R2 read count", 64'(rd_cnt - rb), 64'd8);
        chk("R2 first read addr", rd_log[rb % 512], sa_base);
        chk("R2 last read addr", rd_log[(rb + 7) % 512], sa_base + 64'd28);
        // R3 / R4: copy started only for supported opcodes
        chk(sup ? "R3 copy start count" : "R4 no copy start", 64'(cp_cnt - cb), sup ? 64'd1 : 64'd0);
        if (sup) begin
            chk("R3 length", 64'(cap_len), 64'(len));
            chk("R3 source", cap_src, src);
            chk("R3 destination", cap_dst, dst);
            chk("R3 attributes", 64'({cap_sattr, cap_dattr}), 64'({sa, da}));
        end
        // R5 / R4 / R7: completion record content
        chk("R5 cqe word0", 64'(cq_peek(ca)), 64'd0);
        chk("R5 cqe word1", 64'(cq_peek(ca + 4)), 64'd0);
        chk("R5 cqe head echo", 64'(cq_peek(ca + 8)), 64'(e_head));
        chk("R4 R7 cqe status/valid", 64'(cq_peek(ca + 12)),
            64'({st, e_phase[0], 16'h0000}));
        if (e_tail == int'(cq_depth_m1)) e_phase = 1 - e_phase;
        e_tail = wrapn(e_tail, int'(cq_depth_m1));
        chk("R6 sq head", 64'(sq_head_o), 64'(e_head));
        chk("R7 cq tail", 64'(cq_tail_o), 64'(e_tail));
        chk("R9 irq pulses", 64'(irq_cnt - ib), 64'(irq));
    endtask

    task automatic one_entry(input logic [3:0] op, input logic irq,
                             input logic [31:0] len, input logic [63:0] src,
                             input logic [63:0] dst, input logic free_slot);
        logic [2:0] sa, da;
        sa = 3'($urandom); da = 3'($urandom);
        put_entry(op, irq, sa, da, len, src, dst);
        finish_entry(op, irq, sa, da, len, src, dst);
        if (free_slot) set_cq_head(e_tail);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int r;
        logic [3:0] op;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 sq head after reset", 64'(sq_head_o), 64'd0);
        chk("R1 cq tail after reset", 64'(cq_tail_o), 64'd0);
        chk("R1 no requests after reset", 64'({rd_req, wr_req, cp_start, cpl_irq}), 64'd0);
        // R2: empty ring, no fetch
        repeat (20) @(negedge clk);
        chk("R2 no fetch when empty", 64'(rd_cnt), 64'd0);

        // Directed: fill completion ring (depth 4 holds 3)
        one_entry(4'h4, 1'b1, 32'h0000_1000, 64'hAAAA_0000_1234_5678, 64'hBBBB_0000_8765_4321, 1'b0);
        one_entry(4'h1, 1'b0, 32'h0000_0040, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0010, 1'b0);
        one_entry(4'hF, 1'b1, 32'h0000_0008, 64'h1, 64'h2, 1'b0);

        // R8: completion ring full, engine must stall
        put_entry(4'h4, 1'b0, 3'd5, 3'd2, 32'h77, 64'hC0DE_0000, 64'hF00D_0000);
        repeat (60) @(negedge clk);
        chk("R8 tail held while full", 64'(cq_tail_o), 64'd3);
        chk("R8 no completion written", 64'(cq_peek(cq_base + 64'd60)), 64'hDEAD_BEEF);
        chk("R8 head consumed", 64'(sq_head_o), 64'd4);
        set_cq_head(1);
        finish_entry(4'h4, 1'b0, 3'd5, 3'd2, 32'h77, 64'hC0DE_0000, 64'hF00D_0000);
        set_cq_head(e_tail);

        // Random mix across several wraps of both rings
        for (int n = 0; n < 24; n++) begin
            r = int'($urandom % 4);
            if (r < 2)       op = 4'h4;
            else if (r == 2) op = 4'h1;
            else begin
                op = 4'($urandom);
                if (op == 4'h4 || op == 4'h1) op = 4'h9;
            end
            one_entry(op, 1'($urandom), $urandom,
                      {$urandom, $urandom}, {$urandom, $urandom}, 1'b1);
        end

        // R1: pointer clear
        @(negedge clk);
        ptr_clr = 1'b1;
        @(negedge clk);
        ptr_clr = 1'b0;
        chk("R1 sq head after clear", 64'(sq_head_o), 64'd0);
        chk("R1 cq tail after clear", 64'(cq_tail_o), 64'd0);
        rb = rd_cnt;
        repeat (20) @(negedge clk);
        chk("R1 tail cleared, no fetch", 64'(rd_cnt - rb), 64'd0);
        e_head = 0; e_tail = 0; e_phase = 1;
        one_entry(4'h4, 1'b1, 32'h20, 64'h5000, 64'h6000, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule